// File: doc/BRIEF.md
# Periodic System Tick Timer

A 24-bit down-counting tick timer behind a small word-addressed register port. Once enabled, the count steps down by one on every selected tick. From zero it reloads the programmed period on the next tick and carries on down. A sticky flag records each arrival at zero. An optional one-cycle interrupt pulse marks the step from 1 to 0. Ticks come either from every cycle of the main clock or from an alternate oscillator divided by four. The divided ticks are brought into the main clock domain as a single-cycle enable. A debug-halt input freezes the count.

Software sets the timer up in this order: write the period, write the current-value register to clear it, then set the control bits. Writing the current-value register with any data zeroes the count and the flag and never raises an interrupt. Reading the control word returns the flag and then clears it. A period of zero stops the timer the next time it passes through zero.

Top module: `tick_timer`

## Requirements
- R1: After reset the control word, period, count and flag are all zero and irq_o is low.
- R2: With the enable bit (control bit 0) set, the count drops by exactly one on each selected tick. With enable clear, the count holds.
- R3: The flag (control bit 16) is set when the count steps from 1 to 0. A read of the control word returns the flag and clears it. If a set and a clearing read fall in the same cycle, the set wins.
- R4: A tick that finds the count at zero loads the period register (when non-zero), and decrementing resumes on later ticks.
- R5: A write of any data to the current-value register (offset 0x8) forces the count to zero and clears the flag, and causes no interrupt pulse.
- R6: While dbg_halt_i is high the count does not change.
- R7: irq_o is a pulse of exactly one cycle for each 1-to-0 step taken while control bit 1 is set. With bit 1 clear, irq_o stays low.
- R8: Control bit 2 picks the tick: 1 ticks on every main-clock cycle, 0 ticks once per four rising edges of alt_osc_i.
- R9: With a period of zero, the counter stops at zero on its next wrap and stays there.
- R10: Map: 0x0 control (bit 0 enable, bit 1 interrupt enable, bit 2 source, bit 16 flag, other bits read 0), 0x4 period, 0x8 current count, other offsets read 0. Read data appears on rdata_o in the cycle after the request and holds the value at the request edge. Bits 31:24 of the period and count read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Main clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alt_osc_i | input | 1 | Alternate oscillator, asynchronous to clk_i |
| dbg_halt_i | input | 1 | Debug halt, freezes counting |
| req_i | input | 1 | Bus access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 4 | Byte address of a word register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| irq_o | output | 1 | Interrupt request pulse |

## Verification
The count is sampled by back-to-back reads and by reads a known number of cycles apart, with the timer running, disabled and halted. This separates a correct single-step decrement from a stalled count or a skipped tick. A short period of 3 with the interrupt enabled and then disabled checks the pulse rate, the pulse width and the flag's set/clear-on-read behaviour. A long period cleared in mid-count shows that the clear raises no pulse. A period changed to zero shows the stop. The alternate source runs from an oscillator with a known, unrelated period, so a decrement over a fixed window shows whether the division is by four.

// File: rtl/tt_pkg.sv
package tt_pkg;
  localparam int unsigned OFS_CTRL = 0;
  localparam int unsigned OFS_LOAD = 1;
  localparam int unsigned OFS_CUR  = 2;

  localparam int unsigned BIT_EN   = 0;
  localparam int unsigned BIT_IE   = 1;
  localparam int unsigned BIT_SRC  = 2;
  localparam int unsigned BIT_FLAG = 16;

  typedef struct packed {
    logic src;
    logic ie;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/tt_prescaler.sv
module tt_prescaler #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned PRESC_W     = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic osc_i,
  output logic stb_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;
  logic [PRESC_W-1:0]     div_q;
  logic                   stb_q;
  logic                   rise;

  assign rise  = sync_q[SYNC_STAGES-1] & ~last_q;
  assign stb_o = stb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
      div_q  <= '0;
      stb_q  <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], osc_i};
      last_q <= sync_q[SYNC_STAGES-1];
      stb_q  <= rise && (div_q == '1);
      if (rise) div_q <= div_q + 1'b1;
    end
  end
endmodule

// File: rtl/tt_regs.sv
module tt_regs
  import tt_pkg::*;
#(
  parameter int unsigned CNT_W  = 24,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              flag_i,
  output ctrl_t             ctrl_o,
  output logic [CNT_W-1:0]  reload_o,
  output logic              cur_clr_o,
  output logic              flag_rd_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [1:0]        sel;
  logic              wr, rd;
  logic [DATA_W-1:0] rd_mux;
  ctrl_t             ctrl_q;
  logic [CNT_W-1:0]  reload_q;
  logic [DATA_W-1:0] rdata_q;

  assign sel       = addr_i[3:2];
  assign wr        = req_i & we_i;
  assign rd        = req_i & ~we_i;
  assign cur_clr_o = wr && (sel == 2'(OFS_CUR));
  assign flag_rd_o = rd && (sel == 2'(OFS_CTRL));
  assign ctrl_o    = ctrl_q;
  assign reload_o  = reload_q;
  assign rdata_o   = rdata_q;

  always_comb begin
    rd_mux = '0;
    case (sel)
      2'(OFS_CTRL): begin
        rd_mux[BIT_EN]   = ctrl_q.en;
        rd_mux[BIT_IE]   = ctrl_q.ie;
        rd_mux[BIT_SRC]  = ctrl_q.src;
        rd_mux[BIT_FLAG] = flag_i;
      end
      2'(OFS_LOAD): rd_mux = DATA_W'(reload_q);
      2'(OFS_CUR):  rd_mux = DATA_W'(count_i);
      default:      rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      reload_q <= '0;
      rdata_q  <= '0;
    end else begin
      if (wr && sel == 2'(OFS_CTRL)) begin
        ctrl_q.en  <= wdata_i[BIT_EN];
        ctrl_q.ie  <= wdata_i[BIT_IE];
        ctrl_q.src <= wdata_i[BIT_SRC];
      end
      if (wr && sel == 2'(OFS_LOAD)) reload_q <= wdata_i[CNT_W-1:0];
      if (rd) rdata_q <= rd_mux;
    end
  end
endmodule

// File: rtl/tt_counter.sv
module tt_counter #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_en_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic             clr_i,
  input  logic             flag_rd_i,
  input  logic             ie_i,
  output logic [CNT_W-1:0] count_o,
  output logic             flag_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] count_q;
  logic             flag_q, irq_q;
  logic             step_zero;

  assign step_zero = tick_en_i && !clr_i && (count_q == CNT_W'(1));
  assign count_o   = count_q;
  assign flag_o    = flag_q;
  assign irq_o     = irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      flag_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      if (clr_i) begin
        count_q <= '0;
      end else if (tick_en_i) begin
        if (count_q == '0) begin
          if (reload_i != '0) count_q <= reload_i;
        end else begin
          count_q <= count_q - 1'b1;
        end
      end
      // set beats a clearing read
      if (clr_i)          flag_q <= 1'b0;
      else if (step_zero) flag_q <= 1'b1;
      else if (flag_rd_i) flag_q <= 1'b0;
      irq_q <= step_zero & ie_i;
    end
  end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tt_pkg::*;
#(
  parameter int unsigned CNT_W       = 24,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned PRESC_W     = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alt_osc_i,
  input  logic              dbg_halt_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] reload, count;
  logic             cur_clr, flag_rd, flag;
  logic             alt_stb, tick, tick_en;

  tt_prescaler #(.SYNC_STAGES(SYNC_STAGES), .PRESC_W(PRESC_W)) u_presc (
    .clk_i(clk_i), .rst_ni(rst_ni), .osc_i(alt_osc_i), .stb_o(alt_stb)
  );

  assign tick    = ctrl.src ? 1'b1 : alt_stb;
  assign tick_en = ctrl.en & tick & ~dbg_halt_i;

  tt_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .count_i(count), .flag_i(flag),
    .ctrl_o(ctrl), .reload_o(reload), .cur_clr_o(cur_clr),
    .flag_rd_o(flag_rd), .rdata_o(rdata_o)
  );

  tt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_en_i(tick_en), .reload_i(reload),
    .clr_i(cur_clr), .flag_rd_i(flag_rd), .ie_i(ctrl.ie),
    .count_o(count), .flag_o(flag), .irq_o(irq_o)
  );
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int unsigned CNT_W = 24
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_en,
  input logic             dbg_halt_i,
  input logic             cur_clr,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] reload,
  input logic             flag,
  input logic             irq_o
);
  a_r2_decrement: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_en && !cur_clr && count != '0) |=> count == CNT_W'($past(count) - 1'b1));

  a_r3_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_en && !cur_clr && count == CNT_W'(1)) |=> flag);

  a_r4_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_en && !cur_clr && count == '0 && reload != '0) |=> count == $past(reload));

  a_r5_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_clr |=> (count == '0 && !flag && !irq_o));

  a_r6_halt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_halt_i && !cur_clr) |=> $stable(count));

  a_r7_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  a_r7_irq_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> flag);

  a_r9_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count == '0 && reload == '0 && !cur_clr) |=> count == '0);
endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_en(tick_en), .dbg_halt_i(dbg_halt_i),
  .cur_clr(cur_clr), .count(count), .reload(reload), .flag(flag), .irq_o(irq_o)
);

// File: tb/tick_timer_bench.sv
module tick_timer_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_ni = 1'b0, alt_osc = 1'b0, halt = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        irq;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  tick_timer u_tick_timer (
    .clk_i(clk), .rst_ni(rst_ni), .alt_osc_i(alt_osc), .dbg_halt_i(halt),
    .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always #37 alt_osc = ~alt_osc;

  task automatic chk(input bit ok, input string req_tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req_tag, act, exp);
    end
  endtask

  // all bus tasks start and end at a falling edge
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    d = rdata; req = 1'b0;
  endtask

  task automatic watch_irq(input int cycles, output int pulses, output int dbl);
    bit prev = 1'b0;
    pulses = 0; dbl = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (irq && !prev) pulses++;
      if (irq && prev) dbl++;
      prev = irq;
    end
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk(irq == 1'b0, "R1 irq", irq, 0);
    rd(4'h0, d); chk(d == 0, "R1 ctrl", d, 0);
    rd(4'h4, d); chk(d == 0, "R1 reload", d, 0);
    rd(4'h8, d); chk(d == 0, "R1 count", d, 0);
  endtask

  task automatic t_decrement;
    logic [31:0] a, b, c, e, f;
    wr(4'h4, 1000); wr(4'h8, 0); wr(4'h0, 32'h5);
    repeat (3) @(negedge clk);
    rd(4'h8, a); rd(4'h8, b);
    chk(b == a - 1, "R2 step", b, a - 1);
    repeat (5) @(negedge clk);
    rd(4'h8, c);
    chk(c == b - 6, "R2 rate", c, b - 6);
    wr(4'h0, 32'h4);
    rd(4'h8, e); repeat (3) @(negedge clk); rd(4'h8, f);
    chk(f == e, "R2 disabled hold", f, e);
  endtask

  task automatic t_irq;
    logic [31:0] d;
    int p, dbl;
    wr(4'h4, 3); wr(4'h8, 0); wr(4'h0, 32'h7);
    watch_irq(40, p, dbl);
    chk(p >= 9 && p <= 11, "R7 pulse count", p, 10);
    chk(dbl == 0, "R7 pulse width", dbl, 0);
    chk(p > 0, "R4 wrap repeats", p, 10);
    wr(4'h0, 32'h6);
    rd(4'h0, d); chk(d == 32'h0001_0006, "R3 flag set", d, 32'h0001_0006);
    rd(4'h0, d); chk(d == 32'h6, "R3 clear on read", d, 6);
    wr(4'h0, 32'h5);
    watch_irq(40, p, dbl);
    chk(p == 0, "R7 masked", p, 0);
    wr(4'h0, 32'h4);
    rd(4'h0, d); chk(d[16] == 1'b1, "R3 flag without irq", d[16], 1);
  endtask

  task automatic t_clear;
    logic [31:0] d;
    int p, dbl;
    wr(4'h0, 32'h5); repeat (10) @(negedge clk); wr(4'h0, 32'h4);
    wr(4'h8, 32'hFFFF_FFFF);
    rd(4'h8, d); chk(d == 0, "R5 count zeroed", d, 0);
    rd(4'h0, d); chk(d[16] == 1'b0, "R5 flag cleared", d[16], 0);
    wr(4'h4, 1000); wr(4'h0, 32'h7);
    repeat (10) @(negedge clk);
    wr(4'h8, 32'h1234);
    watch_irq(6, p, dbl);
    chk(p == 0, "R5 no irq on clear", p, 0);
  endtask

  task automatic t_halt;
    logic [31:0] a, b, c, d;
    wr(4'h0, 32'h5);
    repeat (4) @(negedge clk);
    halt = 1'b1;
    repeat (2) @(negedge clk);
    rd(4'h8, a); rd(4'h8, b);
    chk(b == a, "R6 frozen", b, a);
    repeat (2) @(negedge clk);
    halt = 1'b0;
    rd(4'h8, c); rd(4'h8, d);
    chk(c == a, "R6 no loss", c, a);
    chk(d == c - 1, "R6 resume", d, c - 1);
  endtask

  task automatic t_stop;
    logic [31:0] a, b;
    int p, dbl;
    wr(4'h4, 3); wr(4'h8, 0); wr(4'h0, 32'h7);
    repeat (10) @(negedge clk);
    wr(4'h4, 0);
    repeat (20) @(negedge clk);
    rd(4'h8, a); rd(4'h8, b);
    chk(a == 0, "R9 stopped", a, 0);
    chk(b == 0, "R9 stays", b, 0);
    watch_irq(10, p, dbl);
    chk(p == 0, "R9 no more irq", p, 0);
  endtask

  task automatic t_alt;
    logic [31:0] a, b;
    wr(4'h0, 32'h0); wr(4'h4, 1000); wr(4'h8, 0); wr(4'h0, 32'h1);
    repeat (150) @(negedge clk);
    rd(4'h8, a);
    repeat (592) @(negedge clk);
    rd(4'h8, b);
    chk((a - b) >= 19 && (a - b) <= 21, "R8 divide by four", a - b, 20);
  endtask

  task automatic t_map;
    logic [31:0] d;
    wr(4'h0, 32'h0);
    wr(4'h4, 32'hFFFF_FFFF);
    rd(4'h4, d); chk(d == 32'h00FF_FFFF, "R10 reload upper zero", d, 32'h00FF_FFFF);
    wr(4'h0, 32'hFFFF_FFF8);
    rd(4'h0, d); rd(4'h0, d);
    chk(d == 0, "R10 ctrl unused bits", d, 0);
    rd(4'hC, d); chk(d == 0, "R10 unmapped", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_decrement();
    t_irq();
    t_clear();
    t_halt();
    t_stop();
    t_alt();
    t_map();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule